// File: doc/BRIEF.md
# Tag Check Fault Dispatcher

This block receives a single event saying that a memory access failed its allocation-tag comparison. It then decides how the processor responds. The response is read from a 2-bit field of the control register that governs the access's translation regime. The two user-level regimes take their field from one position, and every other regime takes it from a second position. The chosen field picks one of four behaviours: nothing happens, a synchronous abort request is raised, a sticky asynchronous fault bit is set, or the reserved code is flagged for reporting.

The abort request is a one-cycle pulse. It carries the faulting pointer, a fixed fault status code and a flag that says whether the target level is privileged. Asynchronous faults collect in one small status register per exception level. Software clears those bits through a clear-on-write port. Events for accesses whose top-byte-ignore is disabled are dropped, because such accesses are unchecked.

The core must not send events while the selected mode is "no effect". If it does, the block still ignores them.

Top module: `tcf_dispatch`

## Requirements
- R1: After reset, `fault_flags` is zero and `abort_vld` and `rsvd_pulse` are low.
- R2: When `regime_user` is 1, the mode is `ctl_word[39:38]` and the target level is 0, whatever `regime_lvl` holds. An abort raised this way has `abort_priv` = 0.
- R3: When `regime_user` is 0, the mode is `ctl_word[41:40]` and the target level is `regime_lvl`. `abort_priv` is 1 exactly when that level is non-zero.
- R4: Mode 1 makes `abort_vld` high for exactly the cycle after the event. In that cycle `abort_addr` equals `evt_addr` and `abort_fsc` equals 6'h11. Events in consecutive cycles give consecutive pulses, each with its own address.
- R5: Mode 2 sets one bit of `fault_flags` in the cycle after the event. The bit is bit `lvl*2 + s` of `fault_flags`, where `s` is `evt_addr[55]` when `two_ranges` is 1 and 0 otherwise.
- R6: Mode 3 pulses `rsvd_pulse` for one cycle. It raises no abort and leaves `fault_flags` unchanged.
- R7: Mode 0 has no effect: no abort, no reserved pulse, and no flag change.
- R8: An event is dropped when top-byte-ignore is off for its half of the address space: `tbi_hi` is used when `evt_addr[55]` is 1, and `tbi_lo` otherwise.
- R9: Flag bits stay set until cleared. With `clr_vld` high, the bits of `clr_mask` (bit 0 = flag bit `s`=0) are cleared at level `clr_lvl` only, in the following cycle.
- R10: When a set and a clear hit the same flag bit in the same cycle, the bit ends up set. Other bits in the clear mask are still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_vld | input | 1 | Tag-check mismatch event |
| evt_addr | input | 64 | Faulting pointer |
| regime_user | input | 1 | Access uses one of the two user-level regimes |
| regime_lvl | input | 2 | Exception level that owns the regime |
| two_ranges | input | 1 | Target level's regime has two address ranges |
| tbi_lo | input | 1 | Top-byte-ignore enabled for the lower half |
| tbi_hi | input | 1 | Top-byte-ignore enabled for the upper half |
| ctl_word | input | 64 | Governing control register value |
| clr_vld | input | 1 | Clear-on-write strobe for the fault flags |
| clr_lvl | input | 2 | Level whose flags are written |
| clr_mask | input | 2 | Flag bits to clear |
| abort_vld | output | 1 | Synchronous abort request pulse |
| abort_addr | output | 64 | Fault address for the abort |
| abort_fsc | output | 6 | Fault status code |
| abort_priv | output | 1 | Abort targets a non-zero level |
| rsvd_pulse | output | 1 | Reserved mode was selected |
| fault_flags | output | 8 | Sticky flags, two per level, level 0 lowest |

## Verification
The flag update from an asynchronous fault and a software clear can arrive in the same cycle for the same level. The bench provokes this by driving a mode-2 event together with a clear strobe whose mask covers both flag bits of that level. It then checks that only the bit the event targeted survives. The bench also sends back-to-back abort events, to show that the output register reloads on every cycle rather than stretching or merging the pulses.

// File: rtl/tcf_pkg.sv
// Shared constants and types for the tag check fault dispatcher.
// Assumes a 64-bit pointer whose bit 55 selects the address-space half.
package tcf_pkg;
    localparam int unsigned ADDR_W   = 64;
    localparam int unsigned CTL_W    = 64;
    localparam int unsigned LVL_N    = 4;
    localparam int unsigned LVL_W    = $clog2(LVL_N);
    localparam int unsigned FLAG_W   = 2;
    localparam int unsigned IDX_W    = (FLAG_W > 1) ? $clog2(FLAG_W) : 1;
    localparam int unsigned SEL_BIT  = 55;
    localparam int unsigned USER_LSB = 38;
    localparam int unsigned PRIV_LSB = 40;
    localparam int unsigned FSC_W    = 6;
    localparam logic [FSC_W-1:0] FSC_TAG = 6'h11;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_SYNC  = 2'd1,
        MODE_ASYNC = 2'd2,
        MODE_RSVD  = 2'd3
    } tcf_mode_e;

    typedef struct packed {
        logic             vld;
        tcf_mode_e        mode;
        logic [LVL_W-1:0] lvl;
        logic             flag_sel;
        logic             priv;
    } tcf_dec_t;
endpackage

// File: rtl/tcf_mode_sel.sv
// Mode selection: picks the 2-bit fault mode field and the target level
// from the regime kind, and screens out unchecked accesses.
// Assumes the control word belongs to the regime that made the access.
module tcf_mode_sel
    import tcf_pkg::*;
#(
    parameter int unsigned CW   = CTL_W,
    parameter int unsigned ULSB = USER_LSB,
    parameter int unsigned PLSB = PRIV_LSB
) (
    input  logic             evt_vld,
    input  logic             half_bit,
    input  logic             regime_user,
    input  logic [LVL_W-1:0] regime_lvl,
    input  logic             two_ranges,
    input  logic             tbi_lo,
    input  logic             tbi_hi,
    input  logic [CW-1:0]    ctl_word,
    output tcf_dec_t         dec
);
    localparam int unsigned POS_W = $clog2(CW);

    logic [POS_W-1:0] fld_pos;
    logic             checked;

    // Choose the field position for the regime kind.
    always_comb fld_pos = regime_user ? POS_W'(ULSB) : POS_W'(PLSB);

    // Top-byte-ignore of the addressed half decides whether checks apply.
    always_comb checked = half_bit ? tbi_hi : tbi_lo;

    // Assemble the decoded response.
    always_comb begin
        dec          = '0;
        dec.vld      = evt_vld && checked;
        dec.mode     = tcf_mode_e'(ctl_word[fld_pos +: 2]);
        dec.lvl      = regime_user ? '0 : regime_lvl;
        dec.flag_sel = two_ranges ? half_bit : 1'b0;
        dec.priv     = (dec.lvl != '0);
    end
endmodule

// File: rtl/tcf_abort_gen.sv
// Response register: turns a decoded event into a one-cycle abort
// request (with address, status code and privilege flag) or a one-cycle
// reserved-mode pulse. Assumes at most one event per cycle.
module tcf_abort_gen
    import tcf_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned FW = FSC_W,
    parameter logic [FW-1:0] FSC = FSC_TAG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_sync,
    input  logic          fire_rsvd,
    input  logic [AW-1:0] addr,
    input  logic          priv,
    output logic          abort_vld,
    output logic [AW-1:0] abort_addr,
    output logic [FW-1:0] abort_fsc,
    output logic          abort_priv,
    output logic          rsvd_pulse
);
    // Pulse registers, reloaded every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_vld  <= 1'b0;
            rsvd_pulse <= 1'b0;
        end else begin
            abort_vld  <= fire_sync;
            rsvd_pulse <= fire_rsvd;
        end
    end

    // Abort payload, captured with each abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_addr <= '0;
            abort_fsc  <= '0;
            abort_priv <= 1'b0;
        end else if (fire_sync) begin
            abort_addr <= addr;
            abort_fsc  <= FSC;
            abort_priv <= priv;
        end
    end
endmodule

// File: rtl/tcf_sticky_bank.sv
// Sticky fault flags: one small register per level. An asynchronous
// fault sets one bit; a clear-on-write strobe clears the masked bits of
// one level. If both hit the same bit in one cycle, the set wins.
module tcf_sticky_bank
    import tcf_pkg::*;
#(
    parameter int unsigned NL = LVL_N,
    parameter int unsigned FW = FLAG_W,
    parameter int unsigned LW = LVL_W,
    parameter int unsigned IW = IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_vld,
    input  logic [LW-1:0]    set_lvl,
    input  logic [IW-1:0]    set_idx,
    input  logic             clr_vld,
    input  logic [LW-1:0]    clr_lvl,
    input  logic [FW-1:0]    clr_mask,
    output logic [NL*FW-1:0] flags
);
    for (genvar g = 0; g < NL; g++) begin : g_lvl
        logic [FW-1:0] set_v;
        logic [FW-1:0] clr_v;
        logic [FW-1:0] q;

        // Decode the set request for this level.
        always_comb begin
            set_v = '0;
            if (set_vld && (set_lvl == LW'(g))) set_v[set_idx] = 1'b1;
        end

        // Decode the clear request for this level.
        always_comb clr_v = (clr_vld && (clr_lvl == LW'(g))) ? clr_mask : '0;

        // Flag state: clear first, then set, so a new fault is kept.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= (q & ~clr_v) | set_v;
        end

        assign flags[g*FW +: FW] = q;
    end
endmodule

// File: rtl/tcf_dispatch.sv
// Top level of the tag check fault dispatcher. Decodes the mode, routes
// mode 1 to the abort register, mode 2 to the sticky flag bank and
// mode 3 to the reserved pulse. Mode 0 and unchecked events do nothing.
// Latency from event to any output is one clock.
module tcf_dispatch
    import tcf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evt_vld,
    input  logic [ADDR_W-1:0]       evt_addr,
    input  logic                    regime_user,
    input  logic [LVL_W-1:0]        regime_lvl,
    input  logic                    two_ranges,
    input  logic                    tbi_lo,
    input  logic                    tbi_hi,
    input  logic [CTL_W-1:0]        ctl_word,
    input  logic                    clr_vld,
    input  logic [LVL_W-1:0]        clr_lvl,
    input  logic [FLAG_W-1:0]       clr_mask,
    output logic                    abort_vld,
    output logic [ADDR_W-1:0]       abort_addr,
    output logic [FSC_W-1:0]        abort_fsc,
    output logic                    abort_priv,
    output logic                    rsvd_pulse,
    output logic [LVL_N*FLAG_W-1:0] fault_flags
);
    tcf_dec_t dec;
    logic     fire_sync;
    logic     fire_async;
    logic     fire_rsvd;

    tcf_mode_sel u_sel (
        .evt_vld     (evt_vld),
        .half_bit    (evt_addr[SEL_BIT]),
        .regime_user (regime_user),
        .regime_lvl  (regime_lvl),
        .two_ranges  (two_ranges),
        .tbi_lo      (tbi_lo),
        .tbi_hi      (tbi_hi),
        .ctl_word    (ctl_word),
        .dec         (dec)
    );

    // Route the decoded event to exactly one response path.
    always_comb begin
        fire_sync  = dec.vld && (dec.mode == MODE_SYNC);
        fire_async = dec.vld && (dec.mode == MODE_ASYNC);
        fire_rsvd  = dec.vld && (dec.mode == MODE_RSVD);
    end

    tcf_abort_gen u_abort (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_sync  (fire_sync),
        .fire_rsvd  (fire_rsvd),
        .addr       (evt_addr),
        .priv       (dec.priv),
        .abort_vld  (abort_vld),
        .abort_addr (abort_addr),
        .abort_fsc  (abort_fsc),
        .abort_priv (abort_priv),
        .rsvd_pulse (rsvd_pulse)
    );

    tcf_sticky_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vld  (fire_async),
        .set_lvl  (dec.lvl),
        .set_idx  (IDX_W'(dec.flag_sel)),
        .clr_vld  (clr_vld),
        .clr_lvl  (clr_lvl),
        .clr_mask (clr_mask),
        .flags    (fault_flags)
    );
endmodule

// File: rtl/tcf_dispatch_chk.sv
// Checker for tcf_dispatch: relates the event and clear ports to the
// abort, reserved and flag outputs one cycle later.
module tcf_dispatch_chk
    import tcf_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    evt_vld,
    input logic [ADDR_W-1:0]       evt_addr,
    input logic                    regime_user,
    input logic [LVL_W-1:0]        regime_lvl,
    input logic                    two_ranges,
    input logic                    tbi_lo,
    input logic                    tbi_hi,
    input logic [CTL_W-1:0]        ctl_word,
    input logic                    clr_vld,
    input logic [LVL_W-1:0]        clr_lvl,
    input logic [FLAG_W-1:0]       clr_mask,
    input logic                    abort_vld,
    input logic [ADDR_W-1:0]       abort_addr,
    input logic [FSC_W-1:0]        abort_fsc,
    input logic                    abort_priv,
    input logic                    rsvd_pulse,
    input logic [LVL_N*FLAG_W-1:0] fault_flags
);
    // R4: every abort comes from an event in the previous cycle.
    a_r4_abort_has_event: assert property (@(posedge clk) disable iff (!rst_n)
        abort_vld |-> $past(evt_vld));

    // R4: the status code of an abort is the tag-check code.
    a_r4_abort_code: assert property (@(posedge clk) disable iff (!rst_n)
        abort_vld |-> (abort_fsc == FSC_TAG));

    // R2: a user-regime abort is never marked privileged.
    a_r2_user_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_vld && abort_priv) |-> $past(!regime_user));

    // R6: reserved pulse and abort never coincide.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_vld && rsvd_pulse));

    // R8: unchecked events produce no pulse.
    a_r8_unchecked: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && !(evt_addr[SEL_BIT] ? tbi_hi : tbi_lo)) |=> (!abort_vld && !rsvd_pulse));

    // R7: mode 0 produces no pulse.
    a_r7_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld && ((regime_user ? ctl_word[USER_LSB +: 2] : ctl_word[PRIV_LSB +: 2]) == 2'd0))
        |=> (!abort_vld && !rsvd_pulse));

    // R9: without a clear strobe no flag bit falls.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_vld |=> ((fault_flags & $past(fault_flags)) == $past(fault_flags)));
endmodule

bind tcf_dispatch tcf_dispatch_chk u_chk (.*);

// File: tb/tcf_dispatch_test.sv
`timescale 1ns/1ps
module tcf_dispatch_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        evt_vld;
    logic [63:0] evt_addr;
    logic        regime_user;
    logic [1:0]  regime_lvl;
    logic        two_ranges;
    logic        tbi_lo;
    logic        tbi_hi;
    logic [63:0] ctl_word;
    logic        clr_vld;
    logic [1:0]  clr_lvl;
    logic [1:0]  clr_mask;
    logic        abort_vld;
    logic [63:0] abort_addr;
    logic [5:0]  abort_fsc;
    logic        abort_priv;
    logic        rsvd_pulse;
    logic [7:0]  fault_flags;

    int total = 0;
    int bad   = 0;

    localparam logic [63:0] A_HI = 64'h0080_0000_1234_5670; // bit 55 = 1
    localparam logic [63:0] A_LO = 64'h0F00_0000_0000_1000; // bit 55 = 0

    always #2 clk = ~clk;

    tcf_dispatch uut (.*);

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Control word with user field u and privileged field p, noise elsewhere.
    function automatic logic [63:0] ctl_of(input logic [1:0] u, input logic [1:0] p);
        return 64'hA5A5_0000_0000_5A5A | (64'(u) << 38) | (64'(p) << 40);
    endfunction

    // Present one event for one cycle; outputs are valid at the return.
    task automatic send(input logic [63:0] a, input logic usr, input logic [1:0] lvl,
                        input logic two, input logic tl, input logic th, input logic [63:0] c);
        @(negedge clk);
        evt_vld = 1'b1; evt_addr = a; regime_user = usr; regime_lvl = lvl;
        two_ranges = two; tbi_lo = tl; tbi_hi = th; ctl_word = c;
        @(negedge clk);
        evt_vld = 1'b0;
    endtask

    // Present one clear-on-write strobe.
    task automatic clear(input logic [1:0] lvl, input logic [1:0] m);
        @(negedge clk);
        clr_vld = 1'b1; clr_lvl = lvl; clr_mask = m;
        @(negedge clk);
        clr_vld = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 flags", 64'(fault_flags), 64'h0);
        chk("R1 abort", 64'(abort_vld), 64'h0);
        chk("R1 rsvd", 64'(rsvd_pulse), 64'h0);
    endtask

    task automatic t_user_sync;
        send(A_HI, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1, ctl_of(2'd1, 2'd2));
        chk("R2 user field abort", 64'(abort_vld), 64'h1);
        chk("R2 user priv", 64'(abort_priv), 64'h0);
        chk("R4 addr", abort_addr, A_HI);
        chk("R4 fsc", 64'(abort_fsc), 64'h11);
        chk("R2 no flag from priv field", 64'(fault_flags), 64'h0);
        @(negedge clk);
        chk("R4 one cycle", 64'(abort_vld), 64'h0);
    endtask

    task automatic t_priv_sync;
        send(A_LO, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1, ctl_of(2'd2, 2'd1));
        chk("R3 priv field abort", 64'(abort_vld), 64'h1);
        chk("R3 priv flag", 64'(abort_priv), 64'h1);
        chk("R3 addr", abort_addr, A_LO);
        send(A_HI, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, ctl_of(2'd0, 2'd1));
        chk("R3 level0 unpriv", 64'(abort_priv), 64'h0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        evt_vld = 1'b1; evt_addr = A_HI; regime_user = 1'b0; regime_lvl = 2'd1;
        tbi_lo = 1'b1; tbi_hi = 1'b1; ctl_word = ctl_of(2'd0, 2'd1);
        @(negedge clk);
        chk("R4 first pulse", 64'(abort_vld), 64'h1);
        chk("R4 first addr", abort_addr, A_HI);
        evt_addr = A_LO;
        @(negedge clk);
        evt_vld = 1'b0;
        chk("R4 second pulse", 64'(abort_vld), 64'h1);
        chk("R4 second addr", abort_addr, A_LO);
        @(negedge clk);
        chk("R4 ends", 64'(abort_vld), 64'h0);
    endtask

    task automatic t_async;
        send(A_HI, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, ctl_of(2'd1, 2'd2));
        chk("R5 two ranges hi", 64'(fault_flags), 64'h08);
        chk("R5 no abort", 64'(abort_vld), 64'h0);
        send(A_HI, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, ctl_of(2'd0, 2'd2));
        chk("R5 one range", 64'(fault_flags), 64'h48);
        send(A_LO, 1'b1, 2'd2, 1'b1, 1'b1, 1'b1, ctl_of(2'd2, 2'd0));
        chk("R2 user async to level0", 64'(fault_flags), 64'h49);
    endtask

    task automatic t_reserved;
        send(A_HI, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, ctl_of(2'd0, 2'd3));
        chk("R6 pulse", 64'(rsvd_pulse), 64'h1);
        chk("R6 no abort", 64'(abort_vld), 64'h0);
        chk("R6 flags kept", 64'(fault_flags), 64'h49);
        @(negedge clk);
        chk("R6 pulse ends", 64'(rsvd_pulse), 64'h0);
    endtask

    task automatic t_off;
        send(A_HI, 1'b1, 2'd0, 1'b1, 1'b1, 1'b1, ctl_of(2'd0, 2'd1));
        chk("R7 no abort", 64'(abort_vld), 64'h0);
        chk("R7 no rsvd", 64'(rsvd_pulse), 64'h0);
        chk("R7 flags kept", 64'(fault_flags), 64'h49);
    endtask

    task automatic t_unchecked;
        send(A_HI, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, ctl_of(2'd0, 2'd1));
        chk("R8 hi half off", 64'(abort_vld), 64'h0);
        send(A_LO, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, ctl_of(2'd0, 2'd2));
        chk("R8 lo half off flags", 64'(fault_flags), 64'h49);
        send(A_LO, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, ctl_of(2'd0, 2'd3));
        chk("R8 no rsvd", 64'(rsvd_pulse), 64'h0);
    endtask

    task automatic t_clear;
        repeat (3) @(negedge clk);
        chk("R9 held", 64'(fault_flags), 64'h49);
        clear(2'd3, 2'b01);
        chk("R9 clear level3", 64'(fault_flags), 64'h09);
        clear(2'd1, 2'b01);
        chk("R9 masked bit only", 64'(fault_flags), 64'h09);
    endtask

    task automatic t_collide;
        send(A_LO, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, ctl_of(2'd0, 2'd2));
        chk("R5 level1 bit0", 64'(fault_flags), 64'h0D);
        @(negedge clk);
        evt_vld = 1'b1; evt_addr = A_HI; regime_user = 1'b0; regime_lvl = 2'd1;
        two_ranges = 1'b1; tbi_lo = 1'b1; tbi_hi = 1'b1; ctl_word = ctl_of(2'd0, 2'd2);
        clr_vld = 1'b1; clr_lvl = 2'd1; clr_mask = 2'b11;
        @(negedge clk);
        evt_vld = 1'b0; clr_vld = 1'b0;
        chk("R10 set wins", 64'(fault_flags), 64'h09);
        clear(2'd0, 2'b11);
        chk("R9 clear level0", 64'(fault_flags), 64'h08);
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; evt_vld = 1'b0; evt_addr = '0; regime_user = 1'b0;
        regime_lvl = '0; two_ranges = 1'b0; tbi_lo = 1'b1; tbi_hi = 1'b1;
        ctl_word = '0; clr_vld = 1'b0; clr_lvl = '0; clr_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_user_sync;
        t_priv_sync;
        t_back_to_back;
        t_async;
        t_reserved;
        t_off;
        t_unchecked;
        t_clear;
        t_collide;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule